// File: doc/BRIEF.md
# Root Port Error Collector

This block sits in a PCI Express root port and takes in error messages that arrive from below. Each message carries a severity class (correctable, nonfatal or fatal) and a 16-bit requester source ID. The block records the messages in a root error status register, keeps the source ID of the first correctable and the first uncorrectable message, and raises an interrupt. The interrupt is either a one-cycle MSI request carrying a 5-bit message number, or a level INTx output.

Software controls the block through three paths. It can write the three per-class interrupt enables. It can clear status bits by writing ones to them. It can program the message number sent with each MSI request. When software enables a class whose received flag is already set, that pending error raises an interrupt at once. MSI requests fire only when an error condition first appears. INTx instead follows the OR of the enabled, received classes.

Top module: `rp_err_collector`

## Requirements
- R1: Reset clears the command enables, all status bits, both source registers, the message number, `msi_req`, `msi_vec` and `intx`.
- R2: The status bits are: bit 0 correctable received, bit 1 multiple correctable. A correctable message (`msg_sev`=0) sets bit 0. If bit 0 was already set, the message sets bit 1 and leaves `cor_src` unchanged. Otherwise it loads `msg_src` into `cor_src`.
- R3: The status bits are: bit 2 uncorrectable received, bit 3 multiple uncorrectable, bit 5 nonfatal received, bit 6 fatal received. A nonfatal (`msg_sev`=1) or fatal (`msg_sev`=2) message sets bit 2 and its own class bit. If bit 2 was already set, the message sets bit 3. Otherwise it loads `msg_src` into `unc_src`.
- R4: A fatal message sets bit 4 (first uncorrectable was fatal) only when bit 2 was clear before the message.
- R5: With `msi_enable` high, a message pulses `msi_req` for one cycle, one cycle later, when two conditions hold: the command enable of its class is set (bit 0 correctable, bit 1 nonfatal, bit 2 fatal), and that class's received bit (0, 5 or 6) was clear. `msi_vec` then shows the message number that was in effect.
- R6: A command write takes effect the next cycle. With `msi_enable` high, it pulses `msi_req` when any enable bit that goes from 0 to 1 matches a set received bit.
- R7: With `msi_enable` low, after any message, command write or status clear, `intx` equals the OR of enable AND received over the three classes. While `msi_enable` is high, `intx` holds its value.
- R8: A status clear drops every bit set in `sts_clr_mask`. A message in the same cycle is judged against the status as it stands after the clear.
- R9: A message with `msg_sev`=3 changes nothing.
- R10: A `vec_wr` loads `vec_wdata` into `msg_num` the next cycle. An MSI request raised in the same cycle carries the old number.
- R11: A message is gated by the command enables held before a command write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| msg_valid | input | 1 | Error message present |
| msg_sev | input | 2 | Severity: 0 correctable, 1 nonfatal, 2 fatal, 3 ignored |
| msg_src | input | 16 | Source ID of the message |
| msi_enable | input | 1 | Selects MSI signaling instead of INTx |
| cmd_wr | input | 1 | Write strobe for the command enables |
| cmd_wdata | input | 3 | Enables {fatal, nonfatal, correctable} |
| sts_clr | input | 1 | Write-1-to-clear strobe for status |
| sts_clr_mask | input | 7 | Status bits to clear |
| vec_wr | input | 1 | Write strobe for the message number |
| vec_wdata | input | 5 | New message number |
| root_cmd | output | 3 | Current command enables |
| root_sts | output | 7 | Root error status |
| cor_src | output | 16 | Source ID of first correctable |
| unc_src | output | 16 | Source ID of first uncorrectable |
| msg_num | output | 5 | Interrupt message number |
| msi_req | output | 1 | One-cycle MSI request |
| msi_vec | output | 5 | Message number of the last MSI request |
| intx | output | 1 | Level interrupt |

## Verification
Two pairs of events can land in the same cycle: an arriving message together with a status clear, and an arriving message together with a command write. The first pair decides whether the message counts as a first or a repeat error. The second pair decides which enables gate the message. Directed cycles drive each pair on purpose: a clear of the correctable bit alongside a new correctable message, and an enable removal or addition alongside a message. A long stretch of random stimulus then makes these collisions often. A cycle-accurate reference model judges every output on every clock.

// File: rtl/rp_err_collector.sv
module rp_err_collector #(
  parameter int SRC_W = 16,
  parameter int VEC_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             msg_valid,
  input  logic [1:0]       msg_sev,
  input  logic [SRC_W-1:0] msg_src,
  input  logic             msi_enable,
  input  logic             cmd_wr,
  input  logic [2:0]       cmd_wdata,
  input  logic             sts_clr,
  input  logic [6:0]       sts_clr_mask,
  input  logic             vec_wr,
  input  logic [VEC_W-1:0] vec_wdata,
  output logic [2:0]       root_cmd,
  output logic [6:0]       root_sts,
  output logic [SRC_W-1:0] cor_src,
  output logic [SRC_W-1:0] unc_src,
  output logic [VEC_W-1:0] msg_num,
  output logic             msi_req,
  output logic [VEC_W-1:0] msi_vec,
  output logic             intx
);
  localparam int COR = 0, MCOR = 1, UNC = 2, MUNC = 3, FFAT = 4, NFAT = 5, FAT = 6;

  logic [6:0] sts_base, sts_d;
  logic [2:0] cmd_d, rcv_d;
  logic       msg_trig, cmd_trig, cor_ld, unc_ld, evt;

  assign sts_base = sts_clr ? (root_sts & ~sts_clr_mask) : root_sts;
  assign cmd_d    = cmd_wr ? cmd_wdata : root_cmd;

  always_comb begin
    sts_d    = sts_base;
    msg_trig = 1'b0;
    cor_ld   = 1'b0;
    unc_ld   = 1'b0;
    if (msg_valid) begin
      case (msg_sev)
        2'd0: begin
          if (sts_base[COR]) sts_d[MCOR] = 1'b1;
          else begin
            cor_ld   = 1'b1;
            msg_trig = root_cmd[0];
          end
          sts_d[COR] = 1'b1;
        end
        2'd1: begin
          msg_trig    = !sts_base[NFAT] && root_cmd[1];
          sts_d[NFAT] = 1'b1;
        end
        2'd2: begin
          msg_trig   = !sts_base[FAT] && root_cmd[2];
          if (!sts_base[UNC]) sts_d[FFAT] = 1'b1;
          sts_d[FAT] = 1'b1;
        end
        default: ;
      endcase
      if (msg_sev == 2'd1 || msg_sev == 2'd2) begin
        if (sts_base[UNC]) sts_d[MUNC] = 1'b1;
        else unc_ld = 1'b1;
        sts_d[UNC] = 1'b1;
      end
    end
  end

  assign rcv_d    = {sts_d[FAT], sts_d[NFAT], sts_d[COR]};
  assign cmd_trig = cmd_wr && |(cmd_wdata & ~root_cmd & rcv_d);
  assign evt      = (msg_valid && msg_sev != 2'd3) || cmd_wr || sts_clr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      root_cmd <= '0;
      root_sts <= '0;
      cor_src  <= '0;
      unc_src  <= '0;
      msg_num  <= '0;
      msi_req  <= 1'b0;
      msi_vec  <= '0;
      intx     <= 1'b0;
    end else begin
      root_cmd <= cmd_d;
      root_sts <= sts_d;
      if (cor_ld) cor_src <= msg_src;
      if (unc_ld) unc_src <= msg_src;
      if (vec_wr) msg_num <= vec_wdata;
      msi_req <= msi_enable && (msg_trig || cmd_trig);
      if (msi_enable && (msg_trig || cmd_trig)) msi_vec <= msg_num;
      if (!msi_enable && evt) intx <= |(cmd_d & rcv_d);
    end
  end
endmodule

module rp_err_collector_chk #(
  parameter int SRC_W = 16,
  parameter int VEC_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             msg_valid,
  input logic [1:0]       msg_sev,
  input logic [SRC_W-1:0] msg_src,
  input logic             msi_enable,
  input logic             cmd_wr,
  input logic [2:0]       cmd_wdata,
  input logic             sts_clr,
  input logic [6:0]       sts_clr_mask,
  input logic             vec_wr,
  input logic [VEC_W-1:0] vec_wdata,
  input logic [2:0]       root_cmd,
  input logic [6:0]       root_sts,
  input logic [SRC_W-1:0] cor_src,
  input logic [SRC_W-1:0] unc_src,
  input logic [VEC_W-1:0] msg_num,
  input logic             msi_req,
  input logic [VEC_W-1:0] msi_vec,
  input logic             intx
);
  // R6
  cmd_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr |=> root_cmd == $past(cmd_wdata));
  // R5
  msi_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !msi_enable |=> !msi_req);
  // R10
  msi_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (msi_enable && !msi_req) ##1 msi_req |-> msi_vec == $past(msg_num));
  // R7
  intx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    msi_enable |=> $stable(intx));
  // R8
  sts_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sts_clr |=> (($past(root_sts) & ~root_sts) == 7'd0));
  // R2
  cor_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && msg_sev == 2'd0 && !root_sts[0] && !sts_clr) |=> cor_src == $past(msg_src));
  // R9
  ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && msg_sev == 2'd3 && !sts_clr && !cmd_wr) |=> $stable(root_sts) && !msi_req);
endmodule

bind rp_err_collector rp_err_collector_chk #(.SRC_W(SRC_W), .VEC_W(VEC_W)) u_chk (.*);

// File: tb/tb_rp_err_collector.sv
`timescale 1ns/1ps
module tb_rp_err_collector;
  logic clk = 0, rst_n = 0;
  logic msg_valid = 0; logic [1:0] msg_sev = 0; logic [15:0] msg_src = 0;
  logic msi_enable = 0, cmd_wr = 0, sts_clr = 0, vec_wr = 0;
  logic [2:0] cmd_wdata = 0; logic [6:0] sts_clr_mask = 0; logic [4:0] vec_wdata = 0;
  logic [2:0] root_cmd; logic [6:0] root_sts; logic [15:0] cor_src, unc_src;
  logic [4:0] msg_num, msi_vec; logic msi_req, intx;

  int checks = 0, fails = 0; bit done = 0;

  rp_err_collector dut (.*);

  always #2.5 clk = ~clk;

  // reference model
  logic [2:0] m_cmd; logic [6:0] m_sts; logic [15:0] m_cor, m_unc;
  logic [4:0] m_num, m_vec; logic m_msi, m_intx;

  always @(posedge clk) begin
    logic [6:0] b, n; logic [2:0] nc, rv; bit trig, ctrig;
    if (!rst_n) begin
      m_cmd = 0; m_sts = 0; m_cor = 0; m_unc = 0; m_num = 0; m_vec = 0; m_msi = 0; m_intx = 0;
    end else begin
      b = sts_clr ? (m_sts & ~sts_clr_mask) : m_sts;
      n = b; trig = 0;
      if (msg_valid && msg_sev == 0) begin
        if (b[0]) n[1] = 1; else begin m_cor = msg_src; trig = m_cmd[0]; end
        n[0] = 1;
      end
      if (msg_valid && (msg_sev == 1 || msg_sev == 2)) begin
        if (msg_sev == 1) begin trig = !b[5] && m_cmd[1]; n[5] = 1; end
        else begin trig = !b[6] && m_cmd[2]; if (!b[2]) n[4] = 1; n[6] = 1; end
        if (b[2]) n[3] = 1; else m_unc = msg_src;
        n[2] = 1;
      end
      nc = cmd_wr ? cmd_wdata : m_cmd;
      rv = {n[6], n[5], n[0]};
      ctrig = cmd_wr && ((cmd_wdata & ~m_cmd & rv) != 0);
      m_msi = msi_enable && (trig || ctrig);
      if (m_msi) m_vec = m_num;
      if (vec_wr) m_num = vec_wdata;
      if (!msi_enable && ((msg_valid && msg_sev != 3) || cmd_wr || sts_clr)) m_intx = |(nc & rv);
      m_sts = n; m_cmd = nc;
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk("R6 root_cmd", root_cmd, m_cmd);
    chk("R2 R3 R4 R8 root_sts", root_sts, m_sts);
    chk("R2 cor_src", cor_src, m_cor);
    chk("R3 unc_src", unc_src, m_unc);
    chk("R10 msg_num", msg_num, m_num);
    chk("R5 msi_req", msi_req, m_msi);
    chk("R5 msi_vec", msi_vec, m_vec);
    chk("R7 intx", intx, m_intx);
  endtask

  task automatic idle();
    msg_valid = 0; cmd_wr = 0; sts_clr = 0; vec_wr = 0;
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
    compare_all();
    idle();
  endtask

  task automatic send(logic [1:0] s, logic [15:0] id);
    msg_valid = 1; msg_sev = s; msg_src = id;
  endtask

  initial begin
    repeat (3) step();
    // R1
    chk("R1 sts", root_sts, 0); chk("R1 cmd", root_cmd, 0); chk("R1 intx", intx, 0);
    chk("R1 msi", msi_req, 0);
    rst_n = 1;
    msi_enable = 1;
    cmd_wr = 1; cmd_wdata = 3'b111; vec_wr = 1; vec_wdata = 5'd9; step();
    send(0, 16'h1234); step();
    chk("R5 first cor pulse", msi_req, 1); chk("R5 vec", msi_vec, 9); chk("R2 src", cor_src, 16'h1234);
    send(0, 16'h5678); step();
    chk("R2 multi cor", root_sts[1], 1); chk("R2 src kept", cor_src, 16'h1234); chk("R5 no repeat", msi_req, 0);
    send(1, 16'hAAAA); step();
    chk("R3 unc src", unc_src, 16'hAAAA); chk("R3 nf pulse", msi_req, 1);
    send(2, 16'hBBBB); step();
    chk("R4 no first fatal", root_sts[4], 0); chk("R3 multi unc", root_sts[3], 1); chk("R3 src kept", unc_src, 16'hAAAA);
    sts_clr = 1; sts_clr_mask = 7'h7f; step();
    chk("R8 cleared", root_sts, 0);
    send(2, 16'hCCCC); step();
    chk("R4 first fatal", root_sts[4], 1);
    send(3, 16'hDDDD); step();
    chk("R9 ignored", root_sts, 7'h54);
    // R8: clear and message together
    sts_clr = 1; sts_clr_mask = 7'h01; send(0, 16'h0F0F); step();
    chk("R8 reload src", cor_src, 16'h0F0F); chk("R8 no multi", root_sts[1], 0);
    // R11: old enables gate the message
    cmd_wr = 1; cmd_wdata = 3'b001; sts_clr = 1; sts_clr_mask = 7'h7f; step();
    cmd_wr = 1; cmd_wdata = 3'b000; send(0, 16'h1111); step();
    chk("R11 old enable", msi_req, 1);
    // R6: retroactive enable
    cmd_wr = 1; cmd_wdata = 3'b001; step();
    chk("R6 retro msi", msi_req, 1);
    // R7: INTx level
    msi_enable = 0; sts_clr = 1; sts_clr_mask = 7'h7f; step();
    chk("R7 low after clear", intx, 0);
    send(0, 16'h2222); step();
    chk("R7 high", intx, 1);
    sts_clr = 1; sts_clr_mask = 7'h01; step();
    chk("R7 drop", intx, 0);
    for (int i = 0; i < 4000; i++) begin
      msg_valid = ($urandom % 3) == 0; msg_sev = 2'($urandom); msg_src = 16'($urandom);
      cmd_wr = ($urandom % 7) == 0; cmd_wdata = 3'($urandom);
      sts_clr = ($urandom % 6) == 0; sts_clr_mask = 7'($urandom);
      vec_wr = ($urandom % 9) == 0; vec_wdata = 5'($urandom);
      if ($urandom % 40 == 0) msi_enable = ~msi_enable;
      step();
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule